// File: doc/BRIEF.md
# Write-Only Two-Wire Clock Configuration Slave

This block is a write-only slave on a two-wire serial bus (SCL clock line, SDA data line). It holds the control register bank of a clock generator. It samples both bus lines with a fast system clock and finds START and STOP conditions by looking at SDA edges while SCL is high. A transfer is accepted only when its first byte is the fixed write address. The slave then takes and acknowledges two bytes whose contents are discarded. Every data byte after those two is stored in the next register, always beginning at register 0. No sub-address is available, so changing one register means resending every register below it.

The register bank is presented as parallel outputs for the clock generator, together with two views of register 0. One is the pair of output frequency selects. The other is the two-bit operating mode, given both as a raw code and as a one-hot vector. An active-low power-down pin shuts the bus interface off completely and leaves the registers untouched. Only the power-up reset loads the default values. The slave drives SDA only through an open-drain enable.

Top module: `clkcfg_wo_slave`

## Requirements
- R1: After power-up reset, register 0 reads 0x0C and registers 1 to 9 read 0xFF. At that point freq_sel_o is 2'b11, mode_o is 2'b00, mode_sel_o is 4'b0001 and sda_oe_o is 0.
- R2: The slave acknowledges a first byte after START only when that byte equals 0xD2. The upper seven bits are the address and bit 0 is the write flag. Any other byte, including the read form 0xD3, gets no acknowledge and writes no register.
- R3: The two bytes that follow an accepted address byte are both acknowledged and change no register, whatever their values.
- R4: The k-th data byte after the two ignored bytes (k counted from 0) is written to register k for k up to 9. An eleventh or later data byte is not acknowledged and is discarded.
- R5: Bytes are shifted in most significant bit first. An acknowledge keeps the SDA line low for the whole high phase of the ninth SCL pulse.
- R6: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START or STOP that arrives partway through a byte discards the partial byte. After such a START the next byte is again treated as an address.
- R7: While pwrdn_n_i is low, the slave ignores all bus traffic and never drives SDA, and the registers keep their values. Releasing pwrdn_n_i does not reload the defaults.
- R8: freq_sel_o[1] follows register 0 bit 3 and freq_sel_o[0] follows register 0 bit 2. A 1 selects 48 MHz and a 0 selects 24 MHz.
- R9: mode_o is register 0 bits [1:0]: 00 normal, 01 test, 10 spread spectrum, 11 tri-state. mode_sel_o is one-hot, with bit n set when mode_o equals n. Bits 7 to 4 of register 0 do not affect any decoded output.
- R10: sda_oe_o changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than SCL |
| por_n_i | input | 1 | Active-low power-up reset; loads the register defaults |
| pwrdn_n_i | input | 1 | Active-low power-down; low gates off the bus interface |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| regs_o | output | 80 | Register bank; register k at bits [8k+7:8k] |
| freq_sel_o | output | 2 | Output frequency selects from register 0 bits 3 and 2 |
| mode_o | output | 2 | Operating mode code from register 0 bits [1:0] |
| mode_sel_o | output | 4 | One-hot decode of mode_o |

## Verification
The assertions assume three things about the inputs. SDA never changes in the same system-clock window as an SCL edge, so the synchronized copies keep the order of events on the bus. No master issues a STOP or START while the slave holds SDA low for an acknowledge. The SCL low phase lasts longer than the synchronizer delay, which keeps the acknowledge window inside the low phase. The bench drives both lines on falling system-clock edges and holds each bus phase for several system clocks. SDA moves only in the middle of an SCL low phase, except for deliberate START and STOP conditions. The randomized master always releases SDA during the ninth clock, and power-down changes only while the bus is idle.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

   typedef enum logic [1:0] {
      MODE_NORMAL   = 2'b00,
      MODE_TEST     = 2'b01,
      MODE_SPREAD   = 2'b10,
      MODE_TRISTATE = 2'b11
   } op_mode_e;

   typedef enum logic [1:0] {
      BUS_IDLE,
      BUS_RX,
      BUS_ACK,
      BUS_SKIP
   } bus_state_e;

   function automatic logic [3:0] mode_onehot(input op_mode_e m);
      logic [3:0] v;
      v = '0;
      v[m] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/clkcfg_sync.sv
module clkcfg_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] IDLE_VAL = '1
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o,
   output logic [WIDTH-1:0] rise_o,
   output logic [WIDTH-1:0] fall_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clkcfg_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("clkcfg_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];
   logic [WIDTH-1:0] last_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= IDLE_VAL;
         last_q <= IDLE_VAL;
      end else begin
         chain[0] <= d_i;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
         last_q <= chain[STAGES-1];
      end
   end

   assign q_o    = chain[STAGES-1];
   assign rise_o = q_o & ~last_q;
   assign fall_o = ~q_o & last_q;

endmodule

// File: rtl/clkcfg_bus_fsm.sv
module clkcfg_bus_fsm
   import clkcfg_pkg::*;
#(
   parameter int unsigned NREG       = 10,
   parameter logic [7:0]  ADDR_BYTE  = 8'hD2,
   parameter int unsigned SKIP_BYTES = 2,
   parameter int unsigned IDX_W      = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             en_i,
   input  logic             scl_i,
   input  logic             scl_rise_i,
   input  logic             scl_fall_i,
   input  logic             sda_i,
   input  logic             sda_rise_i,
   input  logic             sda_fall_i,
   output logic             sda_oe_o,
   output logic             wr_en_o,
   output logic [IDX_W-1:0] wr_idx_o,
   output logic [7:0]       wr_data_o
);

   localparam int unsigned CNT_W = $clog2(SKIP_BYTES + NREG + 2);
   localparam logic [CNT_W-1:0] FIRST_DATA = CNT_W'(SKIP_BYTES + 1);
   localparam logic [CNT_W-1:0] END_DATA   = CNT_W'(SKIP_BYTES + 1 + NREG);

   generate
      if (NREG < 1 || NREG > 255) begin : g_bad_nreg
         $error("clkcfg_bus_fsm: NREG out of range");
      end
   endgenerate

   bus_state_e       state_q;
   logic [3:0]       bit_cnt_q;
   logic [CNT_W-1:0] byte_cnt_q;
   logic [7:0]       shift_q;

   logic start_ev, stop_ev, byte_done, is_data, accept;
   logic [CNT_W-1:0] data_idx;

   assign start_ev  = scl_i & sda_fall_i;
   assign stop_ev   = scl_i & sda_rise_i;
   assign byte_done = scl_fall_i && (bit_cnt_q == 4'd8);
   assign is_data   = (byte_cnt_q >= FIRST_DATA);
   assign data_idx  = byte_cnt_q - FIRST_DATA;

   always_comb begin
      if (byte_cnt_q == '0)   accept = (shift_q == ADDR_BYTE);
      else if (!is_data)      accept = 1'b1;
      else                    accept = (byte_cnt_q < END_DATA);
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         state_q    <= BUS_IDLE;
         bit_cnt_q  <= '0;
         byte_cnt_q <= '0;
         shift_q    <= '0;
         sda_oe_o   <= 1'b0;
         wr_en_o    <= 1'b0;
         wr_idx_o   <= '0;
         wr_data_o  <= '0;
      end else begin
         wr_en_o <= 1'b0;
         if (!en_i) begin
            state_q  <= BUS_IDLE;
            sda_oe_o <= 1'b0;
         end else if (start_ev) begin
            state_q    <= BUS_RX;
            bit_cnt_q  <= '0;
            byte_cnt_q <= '0;
            sda_oe_o   <= 1'b0;
         end else if (stop_ev) begin
            state_q  <= BUS_IDLE;
            sda_oe_o <= 1'b0;
         end else begin
            unique case (state_q)
               BUS_RX: begin
                  if (scl_rise_i && bit_cnt_q != 4'd8) begin
                     shift_q   <= {shift_q[6:0], sda_i};
                     bit_cnt_q <= bit_cnt_q + 4'd1;
                  end else if (byte_done) begin
                     if (accept) begin
                        sda_oe_o <= 1'b1;
                        state_q  <= BUS_ACK;
                        if (is_data) begin
                           wr_en_o   <= 1'b1;
                           wr_idx_o  <= IDX_W'(data_idx);
                           wr_data_o <= shift_q;
                        end
                     end else begin
                        state_q <= BUS_SKIP;
                     end
                  end
               end
               BUS_ACK: begin
                  if (scl_fall_i) begin
                     sda_oe_o   <= 1'b0;
                     state_q    <= BUS_RX;
                     bit_cnt_q  <= '0;
                     byte_cnt_q <= byte_cnt_q + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R10: the open-drain enable only moves while SCL is low
   p_oe_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (en_i && (sda_oe_o != $past(sda_oe_o))) |-> !scl_i);

   // R4: a write never targets a register outside the bank
   p_wr_idx_range_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      wr_en_o |-> (wr_idx_o < IDX_W'(NREG)));

   // R7: power-down silences the bus side
   p_pd_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !en_i |=> (!sda_oe_o && !wr_en_o));

endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank #(
   parameter int unsigned NREG         = 10,
   parameter int unsigned IDX_W        = (NREG > 1) ? $clog2(NREG) : 1,
   parameter logic [7:0]  REG0_DEFAULT = 8'h0C,
   parameter logic [7:0]  REGN_DEFAULT = 8'hFF
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [7:0]        wr_data_i,
   output logic [NREG*8-1:0] regs_o
);

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam logic [7:0] DEF = (i == 0) ? REG0_DEFAULT : REGN_DEFAULT;
      logic [7:0] val_q;
      always_ff @(posedge clk_i or negedge rst_n_i) begin
         if (!rst_n_i)                                      val_q <= DEF;
         else if (wr_en_i && wr_idx_i == IDX_W'(i))         val_q <= wr_data_i;
      end
      assign regs_o[i*8 +: 8] = val_q;
   end

   // R4: a write strobe lands its byte in the addressed register
   p_write_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (wr_en_i && wr_idx_i < IDX_W'(NREG)) |=>
         (regs_o[$past(wr_idx_i)*8 +: 8] == $past(wr_data_i)));

endmodule

// File: rtl/clkcfg_wo_slave.sv
module clkcfg_wo_slave
   import clkcfg_pkg::*;
#(
   parameter int unsigned NREG         = 10,
   parameter logic [7:0]  ADDR_BYTE    = 8'hD2,
   parameter int unsigned SKIP_BYTES   = 2,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter logic [7:0]  REG0_DEFAULT = 8'h0C,
   parameter logic [7:0]  REGN_DEFAULT = 8'hFF
) (
   input  logic              clk_i,
   input  logic              por_n_i,
   input  logic              pwrdn_n_i,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   output logic [NREG*8-1:0] regs_o,
   output logic [1:0]        freq_sel_o,
   output logic [1:0]        mode_o,
   output logic [3:0]        mode_sel_o
);

   localparam int unsigned IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

   logic [1:0] line_q, line_rise, line_fall;
   logic             wr_en, wr_gated;
   logic [IDX_W-1:0] wr_idx;
   logic [7:0]       wr_data;

   clkcfg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .IDLE_VAL(2'b11)) sync_i (
      .clk_i   (clk_i),
      .rst_n_i (por_n_i),
      .d_i     ({sda_i, scl_i}),
      .q_o     (line_q),
      .rise_o  (line_rise),
      .fall_o  (line_fall)
   );

   clkcfg_bus_fsm #(
      .NREG(NREG), .ADDR_BYTE(ADDR_BYTE), .SKIP_BYTES(SKIP_BYTES), .IDX_W(IDX_W)
   ) fsm_i (
      .clk_i      (clk_i),
      .rst_n_i    (por_n_i),
      .en_i       (pwrdn_n_i),
      .scl_i      (line_q[0]),
      .scl_rise_i (line_rise[0]),
      .scl_fall_i (line_fall[0]),
      .sda_i      (line_q[1]),
      .sda_rise_i (line_rise[1]),
      .sda_fall_i (line_fall[1]),
      .sda_oe_o   (sda_oe_o),
      .wr_en_o    (wr_en),
      .wr_idx_o   (wr_idx),
      .wr_data_o  (wr_data)
   );

   assign wr_gated = wr_en & pwrdn_n_i;

   clkcfg_regbank #(
      .NREG(NREG), .IDX_W(IDX_W),
      .REG0_DEFAULT(REG0_DEFAULT), .REGN_DEFAULT(REGN_DEFAULT)
   ) bank_i (
      .clk_i     (clk_i),
      .rst_n_i   (por_n_i),
      .wr_en_i   (wr_gated),
      .wr_idx_i  (wr_idx),
      .wr_data_i (wr_data),
      .regs_o    (regs_o)
   );

   assign freq_sel_o = regs_o[3:2];
   assign mode_o     = regs_o[1:0];
   assign mode_sel_o = mode_onehot(op_mode_e'(regs_o[1:0]));

   // R7: registers hold while powered down
   p_pd_hold_r7: assert property (@(posedge clk_i) disable iff (!por_n_i)
      !pwrdn_n_i |=> $stable(regs_o));

   // R9: exactly one mode is selected at any time
   p_mode_onehot_r9: assert property (@(posedge clk_i) disable iff (!por_n_i)
      $countones(mode_sel_o) == 1);

endmodule

// File: tb/clkcfg_wo_slave_tb_top.sv
`timescale 1ns/1ps
module clkcfg_wo_slave_tb_top;

   localparam int NREG = 10;
   localparam int Q    = 4;
   localparam logic [7:0] ADDR = 8'hD2;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic pwrdn_n = 1'b1;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic [NREG*8-1:0] regs;
   logic [1:0] freq_sel, mode;
   logic [3:0] mode_sel;
   wire sda_line = sda_m & ~sda_oe;

   int checks = 0;
   int errors = 0;
   logic [7:0] mdl [NREG];

   always #4 clk = ~clk;

   clkcfg_wo_slave dut_i (
      .clk_i(clk), .por_n_i(por_n), .pwrdn_n_i(pwrdn_n),
      .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
      .regs_o(regs), .freq_sel_o(freq_sel), .mode_o(mode), .mode_sel_o(mode_sel)
   );

   function automatic logic [3:0] exp_sel(input logic [1:0] code);
      return 4'b0001 << code;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(2*Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int nbits);
      for (int i = 7; i > 7 - nbits; i--) begin
         sda_m = b[i]; tick(Q);
         scl_m = 1'b1; tick(2*Q);
         scl_m = 1'b0; tick(Q);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      bit low_a, low_b;
      send_bits(b, 8);
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(1);
      low_a = !sda_line; tick(Q);
      low_b = !sda_line;
      ack = low_a && low_b;
      chk(low_a == low_b, "R5", "ack steady through ninth clock", int'(low_b), int'(low_a));
      tick(Q - 1);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic check_regs(input string req);
      for (int k = 0; k < NREG; k++)
         chk(regs[k*8 +: 8] == mdl[k], req, $sformatf("reg%0d", k),
             int'(regs[k*8 +: 8]), int'(mdl[k]));
      chk(freq_sel == mdl[0][3:2], "R8", "freq_sel", int'(freq_sel), int'(mdl[0][3:2]));
      chk(mode == mdl[0][1:0], "R9", "mode", int'(mode), int'(mdl[0][1:0]));
      chk(mode_sel == exp_sel(mdl[0][1:0]), "R9", "mode_sel",
          int'(mode_sel), int'(exp_sel(mdl[0][1:0])));
   endtask

   // full write transfer; n data bytes taken from base pattern
   task automatic run_txn(input logic [7:0] addr, input int n, input logic [7:0] seed_b,
                          input bit rand_data, input string req);
      bit ack;
      bit live;
      logic [7:0] d;
      live = pwrdn_n && (addr == ADDR);
      bus_start();
      send_byte(addr, ack);
      chk(ack == live, "R2", "address ack", int'(ack), int'(live));
      if (ack) begin
         send_byte(8'($urandom), ack);
         chk(ack, "R3", "command byte ack", int'(ack), 1);
         send_byte(8'($urandom), ack);
         chk(ack, "R3", "count byte ack", int'(ack), 1);
         for (int k = 0; k < n; k++) begin
            d = rand_data ? 8'($urandom) : seed_b + 8'(k);
            send_byte(d, ack);
            chk(ack == (k < NREG), "R4", $sformatf("data byte %0d ack", k),
                int'(ack), int'(k < NREG));
            if (!ack) break;
            mdl[k] = d;
         end
      end
      bus_stop();
      tick(4);
      check_regs(req);
   endtask

   initial begin
      bit ack;
      void'($urandom(32'd20240611));
      mdl[0] = 8'h0C;
      for (int k = 1; k < NREG; k++) mdl[k] = 8'hFF;
      tick(5);
      por_n = 1'b1;
      tick(5);

      // R1: defaults after power-up
      chk(sda_oe == 1'b0, "R1", "sda_oe after reset", int'(sda_oe), 0);
      chk(freq_sel == 2'b11, "R1", "freq_sel after reset", int'(freq_sel), 3);
      chk(mode_sel == 4'b0001, "R1", "mode_sel after reset", int'(mode_sel), 1);
      check_regs("R1");

      // R2: read form and foreign address ignored
      run_txn(8'hD3, 3, 8'h00, 1'b0, "R2");
      run_txn(8'h52, 3, 8'h00, 1'b0, "R2");

      // R3: dummy bytes only, no data
      run_txn(ADDR, 0, 8'h00, 1'b0, "R3");

      // R5: MSB-first, single byte to register 0
      run_txn(ADDR, 1, 8'h01, 1'b0, "R5");
      chk(mode == 2'b01, "R5", "mode after 0x01", int'(mode), 1);
      run_txn(ADDR, 1, 8'h80, 1'b0, "R5");
      chk(mode == 2'b00 && freq_sel == 2'b00, "R5", "reg0 after 0x80",
          int'(regs[7:0]), 8'h80);

      // R8: each frequency select bit
      run_txn(ADDR, 1, 8'h08, 1'b0, "R8");
      run_txn(ADDR, 1, 8'h04, 1'b0, "R8");

      // R9: every mode code, reserved bits set
      for (int c = 0; c < 4; c++) begin
         run_txn(ADDR, 1, 8'hF0 | 8'(c), 1'b0, "R9");
         chk(mode_sel == exp_sel(2'(c)), "R9", "mode decode", int'(mode_sel),
             int'(exp_sel(2'(c))));
      end

      // R4: fill all ten, then an eleventh that is refused
      run_txn(ADDR, NREG, 8'h30, 1'b0, "R4");
      run_txn(ADDR, NREG + 2, 8'h60, 1'b0, "R4");

      // R6: restart partway through the second data byte
      bus_start();
      send_byte(ADDR, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
      send_byte(8'hA1, ack); mdl[0] = 8'hA1;
      send_bits(8'h5A, 4);
      scl_m = 1'b0; tick(Q);
      bus_start();
      send_byte(ADDR, ack);
      chk(ack, "R6", "address ack after repeated start", int'(ack), 1);
      send_byte(8'h00, ack); send_byte(8'h00, ack);
      send_byte(8'hB2, ack); mdl[0] = 8'hB2;
      bus_stop(); tick(4);
      check_regs("R6");

      // R6: stop partway through a byte drops it
      bus_start();
      send_byte(ADDR, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
      send_bits(8'h77, 5);
      scl_m = 1'b0; tick(Q);
      bus_stop(); tick(4);
      check_regs("R6");

      // R7: power-down ignores bus and keeps registers
      pwrdn_n = 1'b0; tick(4);
      run_txn(ADDR, 4, 8'h11, 1'b0, "R7");
      chk(sda_oe == 1'b0, "R7", "sda_oe in power-down", int'(sda_oe), 0);
      pwrdn_n = 1'b1; tick(8);
      check_regs("R7");

      // random transfers
      for (int t = 0; t < 24; t++) begin
         logic [7:0] a;
         a = ($urandom % 5 == 0) ? 8'($urandom) : ADDR;
         run_txn(a, int'($urandom % 13), 8'h00, 1'b1, "R4");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule